// File: doc/BRIEF.md
# Four-Way Translation Buffer with Protection Faults

This block turns a 32-bit virtual address into a physical page address for 8 KB pages. It holds two independent translation buffers: one for instruction fetches and one for data loads and stores. Each has four ways of sixteen sets, and each entry is a pair of 32-bit words. A request names the access kind (read, write or execute), whether the requester runs in user mode, the current 8-bit address-space identifier, the memory configuration word and a candidate way from an external replacement picker. The block looks up the four ways at the set picked by the low page-number bits. It checks the access against the entry's protection flags, where the configuration word enables each check, and returns a grant mask or an exception vector.

On a fault that is not a debug probe, the block also updates two words that the refill handler reads. The cause word records the faulting page, the access kind and the identifier. The refill-select word names the set and way to refill. The block then raises a one-cycle pulse so that the external picker advances. Entries are loaded through a single write port that names the buffer, way and set. A response appears two clock edges after the request edge: one edge for the synchronous storage read and one for the registered result.

Top module: `xlat_tlb`

## Requirements
- R1: An entry's hi word carries the virtual page number in bits 31:13 and the identifier in bits 7:0. Its lo word carries the physical page number in bits 31:13 and the flags global (bit 4), valid (bit 3), kernel (bit 2), write (bit 1) and execute (bit 0). The write port stores {hi, lo} into the buffer chosen by `wr_itlb` (1 = instruction, 0 = data), at way `wr_way` and set `wr_set`.
- R2: The page number is vaddr[31:13] and the set is vaddr[16:13]. A way hits when its page number equals the request's page number and either its global flag is set or its identifier equals `req_pid`. On a hit, `rsp_phys` is the matched physical page number shifted left by 13. On a miss it is 0.
- R3: When several ways hit, the lowest-numbered way is used.
- R4: Execute (`req_kind`=2) uses the instruction buffer with vector base 4. Read (0) and write (1) use the data buffer with vector base 8. A miss faults with vector base+0. A value of 3 behaves as a read.
- R5: On a hit, the protection checks are applied in this fixed order, and the first one that fails sets the vector. Kernel: cfg[18], the entry kernel flag and `req_user` all set give base+2. Write: a write with cfg[19] set and the entry write flag clear gives base+3. Execute: an execute with cfg[17] set and the entry execute flag clear gives base+3. Valid: cfg[16] set and the entry valid flag clear gives base+1.
- R6: `rsp_perm` is {exec, write, read}. With no fault, read is 1, write equals the entry write flag, and exec is 1 only for execute requests when cfg[17] or the entry execute flag is set. On any fault `rsp_perm` is 0 and `rsp_vector` is nonzero. With no fault `rsp_vector` is 0.
- R7: On a non-debug fault, `refill_sel` becomes the set in bits 3:0 and a way in bits 5:4, with all other bits 0. The way is the hit way for a protection fault and the sampled `victim_way` for a miss.
- R8: On a non-debug fault, `cause_word` becomes the page number in bits 31:13, the kind code (read 0, write 1, execute 2) in bits 9:8 and `req_pid` in bits 7:0. Bits 12:10 keep their value, which is 0 from reset. Otherwise `cause_word` does not change.
- R9: A request with `req_debug` set returns its normal result, but it updates neither `cause_word` nor `refill_sel` and does not pulse `pick_adv`.
- R10: `pick_adv` pulses for exactly the response cycle of every non-debug fault.
- R11: `rsp_valid` is high for one cycle, two rising edges after the edge that samples `req_valid`. The request fields, including `mm_cfg` and `victim_way`, are sampled at that first edge. Reset clears `rsp_valid`, `pick_adv`, `cause_word` and `refill_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one entry |
| wr_itlb | input | 1 | 1 selects instruction buffer, 0 data buffer |
| wr_way | input | 2 | Way to load |
| wr_set | input | 4 | Set to load |
| wr_hi | input | 32 | Tag word of entry |
| wr_lo | input | 32 | Page and flag word of entry |
| req_valid | input | 1 | Translate request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_user | input | 1 | Requester in user mode |
| req_pid | input | 8 | Current identifier |
| req_debug | input | 1 | Probe with no fault side effects |
| mm_cfg | input | 32 | Check enables in bits 19:16 |
| victim_way | input | 2 | Replacement candidate for misses |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access refused |
| rsp_vector | output | 4 | Exception vector, 0 when no fault |
| rsp_phys | output | 32 | Physical page address |
| rsp_perm | output | 3 | Granted {exec, write, read} |
| cause_word | output | 32 | Fault cause record |
| refill_sel | output | 32 | Set and way for refill |
| pick_adv | output | 1 | Advance the replacement picker |

## Verification
The bench loads both buffers with entries whose page numbers and identifiers come from small pools. This makes hits, global matches, identifier mismatches and several hitting ways common. A design that ignores the global flag or compares the wrong identifier shows up as a wrong miss vector. Directed cases put two hitting ways in one set, to catch a design that picks the highest way. They send a miss with a known victim, to catch a design that reports the hit way instead. They also send debug faults, to catch a design that still updates the cause or refill words or pulses the picker. Random configuration enables against random flags reach every rung of the check order, so a swapped priority or a wrong base for the instruction buffer produces a vector mismatch.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 32;
  localparam int PG_BITS = 13;
  localparam int PID_W   = 8;
  localparam int ENT_W   = 2 * VA_W;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2,
    ACC_RS = 2'd3
  } acc_e;

  // check enables in the configuration word
  localparam int CFG_VCHK = 16;
  localparam int CFG_XCHK = 17;
  localparam int CFG_KCHK = 18;
  localparam int CFG_WCHK = 19;

  // flag positions in the lo word
  localparam int LO_X = 0;
  localparam int LO_W = 1;
  localparam int LO_K = 2;
  localparam int LO_V = 3;
  localparam int LO_G = 4;

  localparam logic [3:0] VEC_IBASE = 4'd4;
  localparam logic [3:0] VEC_DBASE = 4'd8;
endpackage

// File: rtl/tlb_way_ram.sv
module tlb_way_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import xlat_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic                        wr_itlb,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [ENT_W-1:0]            wr_ent,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][ENT_W-1:0]  rd_ient,
  output logic [WAYS-1:0][ENT_W-1:0]  rd_dent
);
  // buffer 0 = instruction, buffer 1 = data
  for (genvar b = 0; b < 2; b++) begin : g_buf
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic            we_bw;
      logic [ENT_W-1:0] q_bw;
      assign we_bw = wr_en && (wr_itlb == (b == 0)) &&
                     (wr_way == WAY_W'(w));
      tlb_way_ram #(.DEPTH(SETS), .DW(ENT_W)) u_ram (
        .clk   (clk),
        .we    (we_bw),
        .waddr (wr_set),
        .wdata (wr_ent),
        .raddr (rd_set),
        .rdata (q_bw)
      );
      if (b == 0) begin : g_i
        assign rd_ient[w] = q_bw;
      end else begin : g_d
        assign rd_dent[w] = q_bw;
      end
    end
  end
endmodule

// File: rtl/tlb_fault_eval.sv
module tlb_fault_eval
  import xlat_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int VPN_W = VA_W - PG_BITS
) (
  input  logic [WAYS-1:0][ENT_W-1:0] ent,
  input  logic [VPN_W-1:0]           page,
  input  logic [PID_W-1:0]           pid,
  input  acc_e                       kind,
  input  logic                       user,
  input  logic [VA_W-1:0]            cfg,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       fault,
  output logic [3:0]                 vec,
  output logic [2:0]                 perm,
  output logic [VA_W-1:0]            phys,
  output logic [1:0]                 code
);
  logic [WAYS-1:0] way_hit;
  logic [VA_W-1:0] sel_lo;
  logic            is_wr, is_ex;
  logic [3:0]      base;

  assign is_wr = (kind == ACC_WR);
  assign is_ex = (kind == ACC_EX);
  assign base  = is_ex ? VEC_IBASE : VEC_DBASE;
  assign code  = is_ex ? 2'd2 : (is_wr ? 2'd1 : 2'd0);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic [VA_W-1:0] hi_w, lo_w;
    assign hi_w = ent[w][ENT_W-1:VA_W];
    assign lo_w = ent[w][VA_W-1:0];
    assign way_hit[w] = (hi_w[VA_W-1:PG_BITS] == page) &&
                        (lo_w[LO_G] || (hi_w[PID_W-1:0] == pid));
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  assign sel_lo = ent[hit_way][VA_W-1:0];
  assign phys   = hit ? {sel_lo[VA_W-1:PG_BITS], {PG_BITS{1'b0}}} : '0;

  always_comb begin
    fault = 1'b1;
    vec   = base;
    perm  = 3'b000;
    if (hit) begin
      if (cfg[CFG_KCHK] && sel_lo[LO_K] && user) begin
        vec = base + 4'd2;
      end else if (is_wr && cfg[CFG_WCHK] && !sel_lo[LO_W]) begin
        vec = base + 4'd3;
      end else if (is_ex && cfg[CFG_XCHK] && !sel_lo[LO_X]) begin
        vec = base + 4'd3;
      end else if (cfg[CFG_VCHK] && !sel_lo[LO_V]) begin
        vec = base + 4'd1;
      end else begin
        fault = 1'b0;
        vec   = 4'd0;
        perm  = {is_ex && (cfg[CFG_XCHK] || sel_lo[LO_X]), sel_lo[LO_W], 1'b1};
      end
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_itlb,
  input  logic [1:0]  wr_way,
  input  logic [3:0]  wr_set,
  input  logic [31:0] wr_hi,
  input  logic [31:0] wr_lo,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic        req_user,
  input  logic [7:0]  req_pid,
  input  logic        req_debug,
  input  logic [31:0] mm_cfg,
  input  logic [1:0]  victim_way,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [3:0]  rsp_vector,
  output logic [31:0] rsp_phys,
  output logic [2:0]  rsp_perm,
  output logic [31:0] cause_word,
  output logic [31:0] refill_sel,
  output logic        pick_adv
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int VPN_W = VA_W - PG_BITS;

  // stage 1: request capture, storage read in flight
  logic             s1_valid, s1_user, s1_dbg;
  logic [VPN_W-1:0] s1_page;
  acc_e             s1_kind;
  logic [PID_W-1:0] s1_pid;
  logic [VA_W-1:0]  s1_cfg;
  logic [WAY_W-1:0] s1_victim;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
    if (req_valid) begin
      s1_page   <= req_vaddr[VA_W-1:PG_BITS];
      s1_kind   <= acc_e'(req_kind);
      s1_user   <= req_user;
      s1_pid    <= req_pid;
      s1_dbg    <= req_debug;
      s1_cfg    <= mm_cfg;
      s1_victim <= victim_way;
    end
  end

  logic [WAYS-1:0][ENT_W-1:0] ent_i, ent_d, ent_sel;

  tlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_itlb (wr_itlb),
    .wr_way  (wr_way),
    .wr_set  (wr_set),
    .wr_ent  ({wr_hi, wr_lo}),
    .rd_set  (req_vaddr[PG_BITS +: SET_W]),
    .rd_ient (ent_i),
    .rd_dent (ent_d)
  );

  assign ent_sel = (s1_kind == ACC_EX) ? ent_i : ent_d;

  logic             ev_hit, ev_fault;
  logic [WAY_W-1:0] ev_way;
  logic [3:0]       ev_vec;
  logic [2:0]       ev_perm;
  logic [VA_W-1:0]  ev_phys;
  logic [1:0]       ev_code;

  tlb_fault_eval #(.WAYS(WAYS)) u_eval (
    .ent     (ent_sel),
    .page    (s1_page),
    .pid     (s1_pid),
    .kind    (s1_kind),
    .user    (s1_user),
    .cfg     (s1_cfg),
    .hit     (ev_hit),
    .hit_way (ev_way),
    .fault   (ev_fault),
    .vec     (ev_vec),
    .perm    (ev_perm),
    .phys    (ev_phys),
    .code    (ev_code)
  );

  // stage 2: registered result and fault records
  logic            side_fx;
  logic [VA_W-1:0] sel_nx;
  assign side_fx = s1_valid && ev_fault && !s1_dbg;

  always_comb begin
    sel_nx = '0;
    sel_nx[SET_W-1:0]       = s1_page[SET_W-1:0];
    sel_nx[SET_W +: WAY_W]  = ev_hit ? ev_way : s1_victim;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_vector <= '0;
      rsp_phys   <= '0;
      rsp_perm   <= '0;
      cause_word <= '0;
      refill_sel <= '0;
      pick_adv   <= 1'b0;
    end else begin
      rsp_valid <= s1_valid;
      pick_adv  <= side_fx;
      if (s1_valid) begin
        rsp_fault  <= ev_fault;
        rsp_vector <= ev_vec;
        rsp_phys   <= ev_phys;
        rsp_perm   <= ev_perm;
      end
      if (side_fx) begin
        cause_word <= {s1_page, cause_word[PG_BITS-1:10], ev_code, s1_pid};
        refill_sel <= sel_nx;
      end
    end
  end
endmodule

// File: rtl/xlat_tlb_sva.sv
module xlat_tlb_sva (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [3:0]  req_set,
  input logic [1:0]  req_kind,
  input logic        req_debug,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [3:0]  rsp_vector,
  input logic [2:0]  rsp_perm,
  input logic [31:0] cause_word,
  input logic [31:0] refill_sel,
  input logic        pick_adv
);
  // R11: response two edges after the request
  assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2));

  // R6: a fault grants nothing and names a vector
  assert_fault_no_perm_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 3'b000 && rsp_vector != 4'd0));

  // R10 / R9: picker pulse only for non-debug faults
  assert_adv_on_fault_R10: assert property (@(posedge clk) disable iff (rst)
    pick_adv |-> (rsp_valid && rsp_fault && !$past(req_debug, 2)));

  // R8: cause record moves only together with a picker pulse
  assert_cause_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cause_word != $past(cause_word)) |-> pick_adv);

  // R7: refill select carries the faulting set
  assert_sel_set_R7: assert property (@(posedge clk) disable iff (rst)
    pick_adv |-> (refill_sel[3:0] == $past(req_set, 2)));

  // R4: execute faults use the instruction vector range
  assert_ivec_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault && $past(req_kind, 2) == 2'd2) |-> (rsp_vector[3:2] == 2'b01));
endmodule

bind xlat_tlb xlat_tlb_sva u_sva (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_set    (req_vaddr[16:13]),
  .req_kind   (req_kind),
  .req_debug  (req_debug),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_vector (rsp_vector),
  .rsp_perm   (rsp_perm),
  .cause_word (cause_word),
  .refill_sel (refill_sel),
  .pick_adv   (pick_adv)
);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_itlb;
  logic [1:0]  wr_way;
  logic [3:0]  wr_set;
  logic [31:0] wr_hi, wr_lo;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_user;
  logic [7:0]  req_pid;
  logic        req_debug;
  logic [31:0] mm_cfg;
  logic [1:0]  victim_way;
  logic        rsp_valid, rsp_fault, pick_adv;
  logic [3:0]  rsp_vector;
  logic [31:0] rsp_phys, cause_word, refill_sel;
  logic [2:0]  rsp_perm;

  always #10 clk = ~clk;

  xlat_tlb i_xlat_tlb (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  logic [31:0] m_cause, m_sel;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // buffer index: 0 = instruction, 1 = data
  task automatic load(input int b, input int w, input int s, input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_itlb = (b == 0); wr_way = 2'(w); wr_set = 4'(s);
    wr_hi = hi; wr_lo = lo;
    @(negedge clk);
    wr_en = 1'b0;
    m_hi[b][w][s] = hi;
    m_lo[b][w][s] = lo;
  endtask

  function automatic logic [31:0] expect_of(input logic [31:0] va, input logic [1:0] kind,
      input logic user, input logic [7:0] pid, input logic [31:0] cfg, input logic [1:0] vic,
      output logic [3:0] vec, output logic [31:0] phys, output logic [2:0] perm, output logic [1:0] way);
    int b;
    logic hit;
    logic [31:0] lo;
    logic [3:0] base;
    logic [3:0] s;
    logic f;
    b = (kind == 2'd2) ? 0 : 1;
    base = (kind == 2'd2) ? 4'd4 : 4'd8;
    s = va[16:13];
    hit = 1'b0; way = vic; lo = '0;
    for (int w = 0; w < 4; w++) begin
      if (!hit && m_hi[b][w][s][31:13] == va[31:13] &&
          (m_lo[b][w][s][4] || m_hi[b][w][s][7:0] == pid)) begin
        hit = 1'b1; way = 2'(w); lo = m_lo[b][w][s];
      end
    end
    phys = hit ? {lo[31:13], 13'd0} : 32'd0;
    perm = 3'b000; f = 1'b1;
    if (!hit) vec = base;
    else if (cfg[18] && lo[2] && user) vec = base + 4'd2;
    else if (kind == 2'd1 && cfg[19] && !lo[1]) vec = base + 4'd3;
    else if (kind == 2'd2 && cfg[17] && !lo[0]) vec = base + 4'd3;
    else if (cfg[16] && !lo[3]) vec = base + 4'd1;
    else begin
      f = 1'b0; vec = 4'd0;
      perm = {kind == 2'd2 && (cfg[17] || lo[0]), lo[1], 1'b1};
    end
    return {31'd0, f};
  endfunction

  task automatic run_req(input logic [31:0] va, input logic [1:0] kind, input logic user,
      input logic [7:0] pid, input logic dbg, input logic [31:0] cfg, input logic [1:0] vic);
    logic [3:0] e_vec; logic [31:0] e_phys; logic [2:0] e_perm; logic [1:0] e_way;
    logic e_fault;
    e_fault = expect_of(va, kind, user, pid, cfg, vic, e_vec, e_phys, e_perm, e_way)[0];
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
    req_pid = pid; req_debug = dbg; mm_cfg = cfg; victim_way = vic;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = '1; mm_cfg = '1; victim_way = ~vic;
    @(negedge clk);
    if (e_fault && !dbg) begin
      m_cause = {va[31:13], m_cause[12:10], (kind == 2'd2) ? 2'd2 : (kind == 2'd1 ? 2'd1 : 2'd0), pid};
      m_sel   = {26'd0, e_way, va[16:13]};
    end
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R4 R5 fault", {31'd0, rsp_fault}, {31'd0, e_fault});
    chk("R4 R5 vector", {28'd0, rsp_vector}, {28'd0, e_vec});
    chk("R2 R3 phys", rsp_phys, e_phys);
    chk("R6 perm", {29'd0, rsp_perm}, {29'd0, e_perm});
    chk("R8 R9 cause", cause_word, m_cause);
    chk("R7 R9 refill_sel", refill_sel, m_sel);
    chk("R10 R9 pick_adv", {31'd0, pick_adv}, {31'd0, e_fault && !dbg});
    @(negedge clk);
    chk("R11 single pulse", {30'd0, rsp_valid, pick_adv}, 32'd0);
  endtask

  function automatic logic [31:0] rnd_hi(input int s);
    return {15'($urandom % 3), 4'(s), 5'd0, 8'($urandom % 3)};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 0; wr_itlb = 0; wr_way = 0; wr_set = 0; wr_hi = 0; wr_lo = 0;
    req_valid = 0; req_vaddr = 0; req_kind = 0; req_user = 0; req_pid = 0;
    req_debug = 0; mm_cfg = 0; victim_way = 0;
    m_cause = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11 reset pick_adv", {31'd0, pick_adv}, 32'd0);
    chk("R11 reset cause", cause_word, 32'd0);
    chk("R11 reset sel", refill_sel, 32'd0);

    // R1: fill both buffers
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 16; s++)
          load(b, w, s, rnd_hi(s), {19'($urandom), 8'd0, 5'($urandom)});

    // R3: two hitting ways in data set 5, lowest wins
    load(1, 0, 5, {15'd200, 4'd5, 13'd7}, 32'h0000_0008);
    load(1, 1, 5, {15'd9, 4'd5, 13'd7}, {19'h1_1111, 13'h18});
    load(1, 3, 5, {15'd9, 4'd5, 13'd7}, {19'h3_3333, 13'h1F});
    run_req({15'd9, 4'd5, 13'h123}, 2'd0, 1'b0, 8'd77, 1'b0, 32'h000F_0000, 2'd0);
    // R2: identifier mismatch without global flag misses
    load(1, 2, 6, {15'd9, 4'd6, 13'd5}, {19'h2_2222, 13'h0B});
    run_req({15'd9, 4'd6, 13'h0}, 2'd0, 1'b0, 8'd6, 1'b0, 32'h0, 2'd1);
    run_req({15'd9, 4'd6, 13'h0}, 2'd1, 1'b0, 8'd5, 1'b0, 32'h0008_0000, 2'd1);
    // R7: miss uses victim way; R4: instruction miss base 4
    run_req({15'd500, 4'd3, 13'h0}, 2'd0, 1'b1, 8'd1, 1'b0, 32'h0, 2'd2);
    run_req({15'd500, 4'd12, 13'h0}, 2'd2, 1'b1, 8'd1, 1'b0, 32'h0, 2'd3);
    // R9: debug fault leaves records untouched
    run_req({15'd501, 4'd9, 13'h0}, 2'd1, 1'b0, 8'd2, 1'b1, 32'h0, 2'd1);
    // R5: kernel beats write in priority
    load(1, 0, 7, {15'd4, 4'd7, 13'd3}, 32'h0000_0004);
    run_req({15'd4, 4'd7, 13'h0}, 2'd1, 1'b1, 8'd3, 1'b0, 32'h000F_0000, 2'd0);

    for (int i = 0; i < 600; i++) begin
      if ($urandom % 8 == 0)
        load($urandom % 2, $urandom % 4, i % 16, rnd_hi(i % 16), {19'($urandom), 8'd0, 5'($urandom)});
      run_req({15'($urandom % 3), 4'($urandom), 13'($urandom)}, 2'($urandom % 3),
              1'($urandom), 8'($urandom % 3), ($urandom % 8 == 0),
              {12'($urandom), 4'($urandom), 16'($urandom)}, 2'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule